// File: doc/BRIEF.md
# Noise-Shaped Multiphase Duty Modulator

This block turns a set of per-phase duty references into one gating bit per inverter phase leg. Once per input period, it takes one fixed-point duty sample for every phase. Each sample carries a few guard bits beyond the tick resolution of the output. Each duty is reduced to a whole number of ticks by a quantizer with error feedback. The feedback stores recent quantization errors and adds them, weighted by an integrator-type filter, to the next sample. This moves the finite-resolution error toward high frequencies, so that the average of the produced duty follows the reference closely. A mode input switches the feedback off and leaves plain rounding.

A free-running tick counter divides every input period into `2^TICK_BITS` ticks. Each quantized duty sets a centred pulse within the period. A strobe on the last tick of every period asks the reference source for the next sample. That sample is captured at the same clock edge and takes effect from the first tick of the next period.

Top module: `noise_shaped_pwm`

## Requirements
- R1: A period is exactly `2^B` ticks (B = TICK_BITS). `period_start` is high on the last tick of each period only. `duty_ref` and `round_only` are captured at the clock edge that ends that tick.
- R2: While `rst` is high at a clock edge, the tick count, all quantized duties and all feedback states return to zero. After reset, every gate is low and the first strobe comes on tick `2^B-1`.
- R3: A captured duty applies to all `2^B` ticks of the following period. Changes on `duty_ref` or `round_only` at any other tick have no effect on the gates.
- R4: For a quantized duty d (0..2^B), a leg is high on the ticks t where lo <= t < lo+d, with lo = floor((2^B-d)/2). A leg therefore has at most two transitions per period.
- R5: A quantized duty of 0 keeps its leg low for the whole period. A quantized duty of `2^B` keeps it high for the whole period.
- R6: With `round_only` = 1, d = floor((u + 2^(F-1)) / 2^F). Here u is the unsigned reference in units of 2^-F tick (F = GUARD_BITS) and ties round up. The error is therefore at most half a tick. In this mode the feedback states are cleared.
- R7: With `round_only` = 0, the quantizer forms a corrected value v. For second order, v = u + 2*e1 - e2. For first order, v = u + e1. It sets d = clamp(floor((v + 2^(F-1)) / 2^F), 0, 2^B). It then stores e1 <= sat(v - d*2^F, ±2^(F-1)) and, for second order, e2 <= old e1. All arithmetic uses shifts and adds only.
- R8: Hold the reference constant with no clamping, starting from cleared states. Over any number of periods, the produced tick total times 2^F differs from the reference total by at most 2^(F+1). Plain rounding keeps a fixed bias per period instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, `2^B` times the input sample rate |
| rst | input | 1 | Synchronous active-high reset |
| round_only | input | 1 | 1 = plain rounding, 0 = error-feedback quantizing; captured with the duty sample |
| duty_ref | input | PHASES*(B+F) | Packed per-phase unsigned duty references, phase 0 in the low bits |
| period_start | output | 1 | High on the last tick of each period; the next sample is taken at its closing edge |
| gate | output | PHASES | Gating bit per leg: 1 = upper switch on, 0 = lower switch on |

## Verification
Per-leg tick counts, first-high positions and transition counts are checked against a bench model of the quantizer. The stimulus is random references drawn over the full range with random mode changes. Directed rails, with zero, full scale and an exact half-tick tie, separate the clamp and rounding-direction paths from the centring arithmetic. During each period, junk is driven onto the inputs to confirm that capture happens only at the period boundary. Two long constant runs at a fractional tick value, one with plain rounding and one with feedback, separate a quantizer that carries its error forward from one that simply rounds.

// File: rtl/ns_pwm_pkg.sv
package ns_pwm_pkg;

    localparam int NS_PHASES     = 5;
    localparam int NS_TICK_BITS  = 8;
    localparam int NS_GUARD_BITS = 4;
    localparam int NS_ORDER      = 2;

    // Quantizer mode captured with each sample.
    typedef enum logic {
        QM_SHAPED = 1'b0,
        QM_ROUND  = 1'b1
    } qmode_e;

    // Control issued by the period counter to every phase slice.
    typedef struct packed {
        logic   load;
        qmode_e mode;
    } period_ctl_t;

endpackage

// File: rtl/ns_tick_counter.sv
module ns_tick_counter #(
    parameter int B = ns_pwm_pkg::NS_TICK_BITS
) (
    input  logic         clk,
    input  logic         rst,
    output logic [B-1:0] tick,
    output logic         wrap
);
    logic [B-1:0] tick_q;

    always_ff @(posedge clk) begin
        if (rst) tick_q <= '0;
        else     tick_q <= tick_q + 1'b1;
    end

    assign tick = tick_q;
    assign wrap = &tick_q;

    // Period boundary always returns the count to zero.
    assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (tick_q == '0));
endmodule

// File: rtl/ns_phase_quant.sv
module ns_phase_quant
    import ns_pwm_pkg::*;
#(
    parameter int B     = NS_TICK_BITS,
    parameter int F     = NS_GUARD_BITS,
    parameter int ORDER = NS_ORDER
) (
    input  logic          clk,
    input  logic          rst,
    input  period_ctl_t   ctl,
    input  logic [B+F-1:0] duty_ref,
    output logic [B:0]    duty_q
);
    localparam int UW = B + F;
    localparam int VW = B + F + 3;
    localparam int EW = F + 2;
    localparam logic signed [VW-1:0] HALF_V = VW'(2 ** (F - 1));
    localparam logic signed [VW-1:0] FULL_V = VW'(2 ** B);
    localparam logic signed [EW-1:0] HALF_E = EW'(2 ** (F - 1));

    logic signed [EW-1:0] e1_q, e_new;
    logic signed [VW-1:0] u_s, e1_x, fb, v, vr, rnd, qerr, y_s;
    logic [B:0]           y, duty_r;
    logic                 bypass;

    assign bypass = (ctl.mode == QM_ROUND);
    assign u_s    = $signed({3'b000, duty_ref});
    assign e1_x   = {{(VW-EW){e1_q[EW-1]}}, e1_q};

    // Weighting filter variant picked by ORDER.
    generate
        if (ORDER == 1) begin : g_first
            assign fb = e1_x;
        end else begin : g_second
            logic signed [EW-1:0] e2_q;
            logic signed [VW-1:0] e2_x;
            assign e2_x = {{(VW-EW){e2_q[EW-1]}}, e2_q};
            assign fb   = (e1_x <<< 1) - e2_x;
            always_ff @(posedge clk) begin
                if (rst)                    e2_q <= '0;
                else if (ctl.load && bypass) e2_q <= '0;
                else if (ctl.load)           e2_q <= e1_q;
            end
            assert_e2_bound_R7: assert property (@(posedge clk) disable iff (rst)
                (e2_q <= HALF_E) && (e2_q >= -HALF_E));
        end
    endgenerate

    always_comb begin
        v   = bypass ? u_s : (u_s + fb);
        vr  = v + HALF_V;
        rnd = vr >>> F;
        if (rnd[VW-1])        y = '0;
        else if (rnd > FULL_V) y = FULL_V[B:0];
        else                   y = rnd[B:0];
        y_s  = $signed({2'b00, y, {F{1'b0}}});
        qerr = v - y_s;
        if (qerr > HALF_V)       e_new = HALF_E;
        else if (qerr < -HALF_V) e_new = -HALF_E;
        else                     e_new = qerr[EW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e1_q   <= '0;
            duty_r <= '0;
        end else if (ctl.load) begin
            duty_r <= y;
            e1_q   <= bypass ? '0 : e_new;
        end
    end

    assign duty_q = duty_r;

    assert_e1_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (e1_q <= HALF_E) && (e1_q >= -HALF_E));
    assert_duty_range_R5: assert property (@(posedge clk) disable iff (rst)
        duty_r <= FULL_V[B:0]);
    assert_round_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl.load && bypass) |=> (e1_q == '0));
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !ctl.load |=> $stable(duty_r));

    logic unused_uw;
    assign unused_uw = (UW == 0);
endmodule

// File: rtl/ns_gate_slicer.sv
module ns_gate_slicer #(
    parameter int B = ns_pwm_pkg::NS_TICK_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [B-1:0] tick,
    input  logic [B:0]   duty_q,
    output logic         gate
);
    localparam logic [B:0] FULL = (B+1)'(2 ** B);

    logic [B:0] lo, hi, tick_x;

    always_comb begin
        tick_x = {1'b0, tick};
        lo     = (FULL - duty_q) >> 1;
        hi     = lo + duty_q;
        gate   = (tick_x >= lo) && (tick_x < hi);
    end

    assert_rail_low_R5: assert property (@(posedge clk) disable iff (rst)
        (duty_q == '0) |-> !gate);
    assert_rail_high_R5: assert property (@(posedge clk) disable iff (rst)
        (duty_q == FULL) |-> gate);
endmodule

// File: rtl/noise_shaped_pwm.sv
module noise_shaped_pwm
    import ns_pwm_pkg::*;
#(
    parameter int PHASES     = NS_PHASES,
    parameter int TICK_BITS  = NS_TICK_BITS,
    parameter int GUARD_BITS = NS_GUARD_BITS,
    parameter int ORDER      = NS_ORDER
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   round_only,
    input  logic [PHASES*(TICK_BITS+GUARD_BITS)-1:0] duty_ref,
    output logic                                   period_start,
    output logic [PHASES-1:0]                      gate
);
    localparam int UW = TICK_BITS + GUARD_BITS;

    logic [TICK_BITS-1:0] tick;
    logic                 wrap;
    period_ctl_t          ctl;

    ns_tick_counter #(.B(TICK_BITS)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .wrap (wrap)
    );

    assign ctl.load     = wrap;
    assign ctl.mode     = round_only ? QM_ROUND : QM_SHAPED;
    assign period_start = wrap;

    generate
        for (genvar p = 0; p < PHASES; p++) begin : g_phase
            logic [TICK_BITS:0] dq;
            ns_phase_quant #(.B(TICK_BITS), .F(GUARD_BITS), .ORDER(ORDER)) u_q (
                .clk      (clk),
                .rst      (rst),
                .ctl      (ctl),
                .duty_ref (duty_ref[p*UW +: UW]),
                .duty_q   (dq)
            );
            ns_gate_slicer #(.B(TICK_BITS)) u_s (
                .clk    (clk),
                .rst    (rst),
                .tick   (tick),
                .duty_q (dq),
                .gate   (gate[p])
            );
        end
    endgenerate

    assert_reset_state_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ((gate == '0) && !period_start));
endmodule

// File: tb/noise_shaped_pwm_tb_top.sv
module noise_shaped_pwm_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 5;
    localparam int B     = 8;
    localparam int F     = 4;
    localparam int ORDER = 2;
    localparam int UW    = B + F;
    localparam int FULL  = 1 << B;
    localparam int HALF  = 1 << (F - 1);
    localparam int RUN   = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic round_only = 1'b0;
    logic [N*UW-1:0] duty_ref = '0;
    logic period_start;
    logic [N-1:0] gate;

    always #(CLK_PERIOD/2) clk = ~clk;

    noise_shaped_pwm #(.PHASES(N), .TICK_BITS(B), .GUARD_BITS(F), .ORDER(ORDER)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .round_only   (round_only),
        .duty_ref     (duty_ref),
        .period_start (period_start),
        .gate         (gate)
    );

    int checks = 0;
    int fails  = 0;
    int tick_i = 0;
    int periods = 0;
    int e1m [N];
    int e2m [N];
    int exp_d [N];
    int hcnt [N];
    int first [N];
    int trans [N];
    bit prevg [N];
    int next_u [N];
    bit next_byp;
    bit cur_byp;
    int next_camp, cur_camp;
    int sum_obs [3][N];

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Quantizer model built from R6 and R7.
    task automatic model_step(input int p, input int u, input bit byp, output int d);
        int v, r, q;
        if (byp)             v = u;
        else if (ORDER == 1) v = u + e1m[p];
        else                 v = u + 2 * e1m[p] - e2m[p];
        r = (v + HALF) >>> F;
        d = (r < 0) ? 0 : ((r > FULL) ? FULL : r);
        q = v - d * (1 << F);
        if (q > HALF)  q = HALF;
        if (q < -HALF) q = -HALF;
        if (byp) begin
            e1m[p] = 0; e2m[p] = 0;
        end else begin
            e2m[p] = e1m[p]; e1m[p] = q;
        end
    endtask

    task automatic end_period();
        chk(tick_i == FULL - 1, "R1 strobe tick", tick_i, FULL - 1);
        for (int p = 0; p < N; p++) begin
            chk(hcnt[p] == exp_d[p], cur_byp ? "R3,R6 high ticks" : "R3,R7 high ticks",
                hcnt[p], exp_d[p]);
            if (exp_d[p] == 0 || exp_d[p] == FULL)
                chk(hcnt[p] == exp_d[p] && trans[p] == 0, "R5 rail level", trans[p], 0);
            else begin
                chk(first[p] == (FULL - exp_d[p]) / 2, "R4 pulse start", first[p],
                    (FULL - exp_d[p]) / 2);
                chk(trans[p] <= 2, "R4 transitions", trans[p], 2);
            end
            sum_obs[cur_camp][p] += hcnt[p];
        end
        for (int p = 0; p < N; p++) begin
            int d;
            duty_ref[p*UW +: UW] = UW'(next_u[p]);
            model_step(p, next_u[p], next_byp, d);
            exp_d[p] = d;
            hcnt[p] = 0; first[p] = -1; trans[p] = 0;
        end
        round_only = next_byp;
        cur_byp = next_byp;
        cur_camp = next_camp;
        tick_i = 0;
        periods++;
    endtask

    task automatic one_tick();
        bit strobe;
        for (int p = 0; p < N; p++) begin
            bit g;
            g = gate[p];
            if (g) begin
                if (hcnt[p] == 0) first[p] = tick_i;
                hcnt[p]++;
            end
            if (tick_i != 0 && g != prevg[p]) trans[p]++;
            prevg[p] = g;
        end
        strobe = period_start;
        if (tick_i == 100) begin
            // Mid-period junk must not reach the gates (R3).
            duty_ref = {$urandom, $urandom};
            round_only = 1'($urandom);
        end
        if (strobe) end_period();
        else tick_i++;
        @(negedge clk);
    endtask

    task automatic run_periods(input int n);
        int target;
        target = periods + n;
        while (periods < target) one_tick();
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1d5e);
        for (int p = 0; p < N; p++) begin
            e1m[p] = 0; e2m[p] = 0; exp_d[p] = 0;
            hcnt[p] = 0; first[p] = -1; trans[p] = 0; prevg[p] = 0; next_u[p] = 0;
            for (int c = 0; c < 3; c++) sum_obs[c][p] = 0;
        end
        next_byp = 0; cur_byp = 0; next_camp = 0; cur_camp = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(gate == '0, "R2 gates low in reset", int'(gate), 0);
        rst = 1'b0;
        chk(gate == '0, "R2 gates low after reset", int'(gate), 0);
        chk(period_start == 1'b0, "R2 no strobe at tick 0", int'(period_start), 0);

        // Directed rails and tie: zero, full-scale, half-tick tie, just below tie.
        next_u[0] = 0; next_u[1] = (1 << UW) - 1; next_u[2] = 4088;
        next_u[3] = 4087; next_u[4] = 24;
        next_byp = 1;
        run_periods(1);
        next_byp = 0;
        run_periods(1);
        next_byp = 1;
        for (int p = 0; p < N; p++) next_u[p] = (p % 2 == 0) ? 0 : (1 << UW) - 1;
        run_periods(1);

        // Constant fractional runs: rounding (campaign 1) then shaped (campaign 2).
        for (int p = 0; p < N; p++) next_u[p] = 68 + 5 * p;
        next_byp = 1; next_camp = 1;
        run_periods(RUN);
        next_byp = 0; next_camp = 2;
        run_periods(RUN);
        next_camp = 0;

        // Constrained random mix.
        for (int k = 0; k < 120; k++) begin
            for (int p = 0; p < N; p++) begin
                int sel;
                sel = int'($urandom % 10);
                if (sel == 0)      next_u[p] = 0;
                else if (sel == 1) next_u[p] = (1 << UW) - 1 - int'($urandom % 16);
                else               next_u[p] = int'($urandom % (1 << UW));
            end
            next_byp = (($urandom % 4) == 0);
            run_periods(1);
        end
        run_periods(1);

        for (int p = 0; p < N; p++) begin
            int u, rb, diff;
            u  = 68 + 5 * p;
            rb = ((u + HALF) >> F) * RUN;
            chk(sum_obs[1][p] == rb, "R8 rounding keeps bias", sum_obs[1][p], rb);
            diff = sum_obs[2][p] * (1 << F) - u * RUN;
            if (diff < 0) diff = -diff;
            chk(diff <= (1 << (F + 1)), "R8 shaped total tracks reference", diff, 1 << (F + 1));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", periods, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule